// File: doc/BRIEF.md
# DDR Command Bus Timing Checker

A passive observer placed on a DDR SDRAM command bus. At every rising clock edge it decodes the command from clock enable, chip select, the three strobes, the bank address and address bit 10. It keeps an open or closed state for each of four banks and runs elapsed-cycle counters for every spacing rule. When a command breaks a bank-state rule or comes too early, it reports that command with a nonzero violation code. Every limit is a cycle-count parameter. The default values match a 6 ns clock.

All three outputs are registered and follow the edge that sampled the command: the decoded command, the bank-open vector, and the violation flag with its code. The model follows the bus as issued. A flagged command still changes bank state and restarts its counters, with one exception: a read or write to a closed bank has no effect. Burst length comes from the operand of the mode register command and sets both the auto-precharge windows and write recovery.

Top module: `ddr_cmd_checker`

## Requirements
- R1: With clock enable high, {cs_ni,ras_ni,cas_ni,we_ni} decodes as follows: 0000 is mode set (ba_i=0, code 10) or extended mode set (other ba_i, code 11); 0011 is activate (2); 0101 is read (3), or read with auto-precharge (4) when a10_i=1; 0100 is write (5), or write with auto-precharge (6) when a10_i=1; 0010 is precharge (7), or precharge-all (8) when a10_i=1; 0001 is refresh (9); 0110 is burst stop (12); 0111 is no-op (1); cs_ni high is deselect (0); clock enable low is suspend (13). cmd_o shows the code one edge after sampling, and a no-op never raises viol_o.
- R2: After reset, cmd_o is 0, every bank is closed, viol_o is 0, and every timer is saturated, so the first command is legal.
- R3: Activate sets bank_open_o[ba_i]. Precharge with a10_i=0 clears only bank ba_i. Precharge with a10_i=1 clears every bank and ignores ba_i.
- R4: State codes are: activate of an open bank gives 1, read or write of a closed bank gives 2, and refresh or either mode set while any bank is open gives 3.
- R5: Activate of bank b needs at least tRP (3) cycles since b closed, or code 7. It needs at least tRC (10) cycles since the last activate of b, or code 6. It needs at least tRRD (2) cycles since any activate, or code 8.
- R6: Read or write needs at least tRCD (3) cycles since the bank's activate, or code 4. It needs at least tCCD (1) cycle since the last read or write, or code 9. Back-to-back reads are legal.
- R7: Precharge of an open bank needs at least tRAS (7) cycles since its activate, or code 5. It needs at least BL/2+1+tWR cycles since the last write to that bank, or code 10.
- R8: A read with auto-precharge at cycle n closes the bank and marks it busy until n + max(BL/2, tRAS - cycles since activate) + tRP. It may therefore be issued at tRCD. A command that targets a busy bank before that cycle gives code 11.
- R9: A write with auto-precharge at cycle n marks the bank busy until n + max(BL/2+1+tWR, tRAS - cycles since activate) + tRP, with code 11 as in R8.
- R10: A mode set with mode_op_i 1, 2 or 3 sets the burst length to 2, 4 or 8. Any other operand, and every extended mode set, leaves the burst length unchanged. The burst length after reset is 4.
- R11: After a mode set, any command other than no-op, deselect or suspend needs at least tMRD (2) cycles, or code 13. After a refresh, the same applies with tRFC (12) cycles, or code 12. Refresh and mode sets need every bank closed for at least tRP, or code 7.
- R12: When several rules fail, the code reported is chosen in this order: state codes, then auto-precharge busy, then tMRD, then tRFC, then the per-command spacing codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge samples |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock enable seen on the bus |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | Address bit 10 (auto-precharge / all-banks) |
| mode_op_i | input | 3 | Low address bits, burst-length field of mode set |
| cmd_o | output | 4 | Decoded command code of the previous edge |
| bank_open_o | output | 4 | Per-bank open state |
| viol_o | output | 1 | Previous command broke a rule |
| viol_code_o | output | 4 | Violation code, 0 when none |

## Verification
The properties assume that every bus input is a known 0 or 1 at each rising edge once reset is released. They also assume that clock enable, chip select and the strobes change only between edges. The bench drives all inputs on the falling edge, always from defined values, and holds a no-op between commands. Each scenario starts from a quiet bus: at least 16 idle cycles, a precharge-all, then 16 more idle cycles. That way each expected code depends only on the commands inside the scenario.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,  CMD_NOP  = 4'd1,  CMD_ACT  = 4'd2,  CMD_RD   = 4'd3,
    CMD_RDA   = 4'd4,  CMD_WR   = 4'd5,  CMD_WRA  = 4'd6,  CMD_PRE  = 4'd7,
    CMD_PREA  = 4'd8,  CMD_REF  = 4'd9,  CMD_MRS  = 4'd10, CMD_EMRS = 4'd11,
    CMD_BST   = 4'd12, CMD_SUSP = 4'd13
  } cmd_e;

  typedef enum logic [3:0] {
    V_NONE = 4'd0, V_ACT_OPEN = 4'd1, V_COL_CLOSED = 4'd2, V_NOT_IDLE = 4'd3,
    V_RCD  = 4'd4, V_RAS = 4'd5, V_RC = 4'd6, V_RP = 4'd7, V_RRD = 4'd8,
    V_CCD  = 4'd9, V_WR  = 4'd10, V_AP_BUSY = 4'd11, V_RFC = 4'd12, V_MRD = 4'd13
  } viol_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_chk_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cke_i,
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  output cmd_e            cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cke_i)     cmd_o = CMD_SUSP;
    else if (cs_ni) cmd_o = CMD_DESEL;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000: cmd_o = (ba_i == '0) ? CMD_MRS : CMD_EMRS;
        3'b001: cmd_o = CMD_REF;
        3'b010: cmd_o = a10_i ? CMD_PREA : CMD_PRE;
        3'b011: cmd_o = CMD_ACT;
        3'b100: cmd_o = a10_i ? CMD_WRA : CMD_WR;
        3'b101: cmd_o = a10_i ? CMD_RDA : CMD_RD;
        3'b110: cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
  parameter int CNT_W = 6,
  parameter int T_RAS = 7,
  parameter int T_RP  = 3,
  parameter int T_WR  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             col_i,
  input  logic             wr_i,
  input  logic             ap_i,
  input  logic [3:0]       bl_half_i,
  output logic             open_o,
  output logic [CNT_W-1:0] since_act_o,
  output logic [CNT_W-1:0] since_pre_o,
  output logic [CNT_W-1:0] since_wr_o,
  output logic [CNT_W-1:0] ap_rem_o
);
  localparam logic [CNT_W-1:0] SAT = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] inc(input logic [CNT_W-1:0] v);
    return (v == SAT) ? v : v + ONE;
  endfunction

  int base_c, lock_c, hold_c;
  logic [CNT_W-1:0] ap_dly;

  // internal precharge waits for the burst (plus recovery) and for tRAS
  always_comb begin
    base_c = int'(bl_half_i) + (wr_i ? 1 + T_WR : 0);
    lock_c = T_RAS - int'(since_act_o);
    hold_c = (lock_c > base_c) ? lock_c : base_c;
    ap_dly = CNT_W'(hold_c + T_RP - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o      <= 1'b0;
      since_act_o <= SAT;
      since_pre_o <= SAT;
      since_wr_o  <= SAT;
      ap_rem_o    <= '0;
    end else begin
      since_act_o <= act_i ? ONE : inc(since_act_o);
      since_pre_o <= inc(since_pre_o);
      since_wr_o  <= inc(since_wr_o);
      ap_rem_o    <= (ap_rem_o == '0) ? '0 : ap_rem_o - ONE;
      if (act_i) begin
        open_o <= 1'b1;
      end else if (pre_i && open_o) begin
        open_o      <= 1'b0;
        since_pre_o <= ONE;
      end else if (col_i && open_o) begin
        if (wr_i) since_wr_o <= ONE;
        if (ap_i) begin
          open_o      <= 1'b0;
          ap_rem_o    <= ap_dly;
          since_pre_o <= SAT;
        end
      end
    end
  end
endmodule

// File: rtl/ddr_rule_eval.sv
module ddr_rule_eval
  import ddr_chk_pkg::*;
#(
  parameter int NB    = 4,
  parameter int BA_W  = 2,
  parameter int CNT_W = 6,
  parameter int T_RC  = 10,
  parameter int T_RAS = 7,
  parameter int T_RCD = 3,
  parameter int T_RRD = 2,
  parameter int T_RP  = 3,
  parameter int T_WR  = 3,
  parameter int T_CCD = 1,
  parameter int T_RFC = 12,
  parameter int T_MRD = 2
) (
  input  cmd_e             cmd_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic [NB-1:0]    open_i,
  input  logic [CNT_W-1:0] since_act_i [NB],
  input  logic [CNT_W-1:0] since_pre_i [NB],
  input  logic [CNT_W-1:0] since_wr_i  [NB],
  input  logic [CNT_W-1:0] ap_rem_i    [NB],
  input  logic [CNT_W-1:0] since_act_any_i,
  input  logic [CNT_W-1:0] since_col_i,
  input  logic [CNT_W-1:0] since_ref_i,
  input  logic [CNT_W-1:0] since_mrs_i,
  input  logic [3:0]       bl_half_i,
  output viol_e            code_o
);
  localparam logic [CNT_W-1:0] C_RC  = CNT_W'(T_RC);
  localparam logic [CNT_W-1:0] C_RAS = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] C_RCD = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] C_RRD = CNT_W'(T_RRD);
  localparam logic [CNT_W-1:0] C_RP  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] C_WRR = CNT_W'(T_WR + 1);
  localparam logic [CNT_W-1:0] C_CCD = CNT_W'(T_CCD);
  localparam logic [CNT_W-1:0] C_RFC = CNT_W'(T_RFC);
  localparam logic [CNT_W-1:0] C_MRD = CNT_W'(T_MRD);

  logic [CNT_W-1:0] wr_gap;
  logic is_real, is_col, is_glob, any_open, any_busy, rp_short, pa_ras, pa_wr;

  always_comb begin
    wr_gap   = CNT_W'(bl_half_i) + C_WRR;
    is_real  = !(cmd_i inside {CMD_DESEL, CMD_NOP, CMD_SUSP});
    is_col   = cmd_i inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA};
    is_glob  = cmd_i inside {CMD_REF, CMD_MRS, CMD_EMRS};
    any_open = |open_i;
    any_busy = 1'b0;
    rp_short = 1'b0;
    pa_ras   = 1'b0;
    pa_wr    = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (ap_rem_i[b] != '0)   any_busy = 1'b1;
      if (since_pre_i[b] < C_RP) rp_short = 1'b1;
      if (open_i[b] && since_act_i[b] < C_RAS) pa_ras = 1'b1;
      if (open_i[b] && since_wr_i[b] < wr_gap) pa_wr = 1'b1;
    end

    code_o = V_NONE;
    if (is_real) begin
      if (cmd_i == CMD_ACT && open_i[ba_i])                 code_o = V_ACT_OPEN;
      else if (is_col && !open_i[ba_i])                     code_o = V_COL_CLOSED;
      else if (is_glob && any_open)                         code_o = V_NOT_IDLE;
      else if (((cmd_i inside {CMD_ACT, CMD_PRE} || is_col) && ap_rem_i[ba_i] != '0) ||
               ((cmd_i == CMD_PREA || is_glob) && any_busy)) code_o = V_AP_BUSY;
      else if (since_mrs_i < C_MRD)                         code_o = V_MRD;
      else if (since_ref_i < C_RFC)                         code_o = V_RFC;
      else begin
        unique case (cmd_i)
          CMD_ACT: begin
            if (since_pre_i[ba_i] < C_RP)       code_o = V_RP;
            else if (since_act_i[ba_i] < C_RC)  code_o = V_RC;
            else if (since_act_any_i < C_RRD)   code_o = V_RRD;
          end
          CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
            if (since_act_i[ba_i] < C_RCD)      code_o = V_RCD;
            else if (since_col_i < C_CCD)       code_o = V_CCD;
          end
          CMD_PRE: begin
            if (open_i[ba_i] && since_act_i[ba_i] < C_RAS)     code_o = V_RAS;
            else if (open_i[ba_i] && since_wr_i[ba_i] < wr_gap) code_o = V_WR;
          end
          CMD_PREA: begin
            if (pa_ras)     code_o = V_RAS;
            else if (pa_wr) code_o = V_WR;
          end
          CMD_REF, CMD_MRS, CMD_EMRS: begin
            if (rp_short) code_o = V_RP;
          end
          default: code_o = V_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
  import ddr_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 6,
  parameter int T_RC      = 10,
  parameter int T_RAS     = 7,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 3,
  parameter int T_WR      = 3,
  parameter int T_CCD     = 1,
  parameter int T_RFC     = 12,
  parameter int T_MRD     = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  input  logic [2:0]           mode_op_i,
  output logic [3:0]           cmd_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 viol_o,
  output logic [3:0]           viol_code_o
);
  localparam logic [CNT_W-1:0] SAT = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] inc(input logic [CNT_W-1:0] v);
    return (v == SAT) ? v : v + ONE;
  endfunction

  cmd_e  cmd, cmd_q;
  viol_e code, code_q;
  logic  viol_q;
  logic  is_col, is_wr, is_ap;
  logic [3:0]       bl_half;
  logic [CNT_W-1:0] since_act_any, since_col, since_ref, since_mrs;
  logic [CNT_W-1:0] since_act [NUM_BANKS];
  logic [CNT_W-1:0] since_pre [NUM_BANKS];
  logic [CNT_W-1:0] since_wr  [NUM_BANKS];
  logic [CNT_W-1:0] ap_rem    [NUM_BANKS];

  ddr_cmd_decode #(.BA_W(BA_W)) u_dec (
    .cke_i (cke_i),  .cs_ni (cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
    .we_ni (we_ni),  .ba_i  (ba_i),  .a10_i (a10_i),  .cmd_o (cmd)
  );

  assign is_col = cmd inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA};
  assign is_wr  = cmd inside {CMD_WR, CMD_WRA};
  assign is_ap  = cmd inside {CMD_RDA, CMD_WRA};

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (ba_i == BA_W'(g));
    ddr_bank_track #(.CNT_W(CNT_W), .T_RAS(T_RAS), .T_RP(T_RP), .T_WR(T_WR)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (cmd == CMD_ACT && hit),
      .pre_i      ((cmd == CMD_PRE && hit) || cmd == CMD_PREA),
      .col_i      (is_col && hit),
      .wr_i       (is_wr),
      .ap_i       (is_ap),
      .bl_half_i  (bl_half),
      .open_o     (bank_open_o[g]),
      .since_act_o(since_act[g]),
      .since_pre_o(since_pre[g]),
      .since_wr_o (since_wr[g]),
      .ap_rem_o   (ap_rem[g])
    );
  end

  ddr_rule_eval #(
    .NB(NUM_BANKS), .BA_W(BA_W), .CNT_W(CNT_W), .T_RC(T_RC), .T_RAS(T_RAS),
    .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RP(T_RP), .T_WR(T_WR), .T_CCD(T_CCD),
    .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_eval (
    .cmd_i          (cmd),
    .ba_i           (ba_i),
    .open_i         (bank_open_o),
    .since_act_i    (since_act),
    .since_pre_i    (since_pre),
    .since_wr_i     (since_wr),
    .ap_rem_i       (ap_rem),
    .since_act_any_i(since_act_any),
    .since_col_i    (since_col),
    .since_ref_i    (since_ref),
    .since_mrs_i    (since_mrs),
    .bl_half_i      (bl_half),
    .code_o         (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act_any <= SAT;
      since_col     <= SAT;
      since_ref     <= SAT;
      since_mrs     <= SAT;
      bl_half       <= 4'd2;
      cmd_q         <= CMD_DESEL;
      code_q        <= V_NONE;
      viol_q        <= 1'b0;
    end else begin
      since_act_any <= (cmd == CMD_ACT) ? ONE : inc(since_act_any);
      since_col     <= is_col ? ONE : inc(since_col);
      since_ref     <= (cmd == CMD_REF) ? ONE : inc(since_ref);
      since_mrs     <= (cmd inside {CMD_MRS, CMD_EMRS}) ? ONE : inc(since_mrs);
      if (cmd == CMD_MRS) begin
        unique case (mode_op_i)
          3'd1:    bl_half <= 4'd1;
          3'd2:    bl_half <= 4'd2;
          3'd3:    bl_half <= 4'd4;
          default: bl_half <= bl_half;
        endcase
      end
      cmd_q  <= cmd;
      code_q <= code;
      viol_q <= (code != V_NONE);
    end
  end

  assign cmd_o       = cmd_q;
  assign viol_code_o = code_q;
  assign viol_o      = viol_q;
endmodule

// File: rtl/ddr_cmd_checker_sva.sv
module ddr_cmd_checker_sva
  import ddr_chk_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cke_i,
  input logic            cs_ni,
  input logic            ras_ni,
  input logic            cas_ni,
  input logic            we_ni,
  input logic [BA_W-1:0] ba_i,
  input logic            a10_i,
  input logic [3:0]      cmd_o,
  input logic [NB-1:0]   bank_open_o,
  input logic            viol_o,
  input logic [3:0]      viol_code_o
);
  logic sel, act_in, col_in, prea_in, nop_in;
  assign sel     = cke_i && !cs_ni;
  assign act_in  = sel && !ras_ni &&  cas_ni &&  we_ni;
  assign col_in  = sel &&  ras_ni && !cas_ni;
  assign prea_in = sel && !ras_ni &&  cas_ni && !we_ni && a10_i;
  assign nop_in  = sel &&  ras_ni &&  cas_ni &&  we_ni;

  p_desel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && cs_ni) |=> cmd_o == CMD_DESEL);

  p_nop_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_in |=> !viol_o);

  p_act_opens_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_in |=> bank_open_o[$past(ba_i)]);

  p_prea_closes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prea_in |=> bank_open_o == '0);

  p_act_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_in && bank_open_o[ba_i]) |=> viol_code_o == V_ACT_OPEN);

  p_col_closed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_in && !bank_open_o[ba_i]) |=> viol_code_o == V_COL_CLOSED && viol_o);
endmodule

bind ddr_cmd_checker ddr_cmd_checker_sva #(.NB(NUM_BANKS), .BA_W(BA_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
  .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i), .a10_i(a10_i), .cmd_o(cmd_o),
  .bank_open_o(bank_open_o), .viol_o(viol_o), .viol_code_o(viol_code_o)
);

// File: tb/ddr_cmd_checker_tb.sv
module ddr_cmd_checker_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic       a10 = 1'b0;
  logic [2:0] op = '0;
  logic [3:0] cmd_o, bank_open, code;
  logic       viol;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  ddr_cmd_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a10_i(a10), .mode_op_i(op),
    .cmd_o(cmd_o), .bank_open_o(bank_open), .viol_o(viol), .viol_code_o(code)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic issue(input logic k, input logic [3:0] c, input logic [1:0] b,
                       input logic a, input logic [2:0] o);
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = c; ba = b; a10 = a; op = o;
    @(posedge clk);
    #1;
  endtask

  task automatic nop();            issue(1, 4'b0111, 0, 0, 0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) nop(); endtask
  task automatic act(input logic [1:0] b); issue(1, 4'b0011, b, 0, 0); endtask
  task automatic rd(input logic [1:0] b, input logic ap); issue(1, 4'b0101, b, ap, 0); endtask
  task automatic wr(input logic [1:0] b, input logic ap); issue(1, 4'b0100, b, ap, 0); endtask
  task automatic pre(input logic [1:0] b); issue(1, 4'b0010, b, 0, 0); endtask
  task automatic prea(input logic [1:0] b); issue(1, 4'b0010, b, 1, 0); endtask
  task automatic refr(); issue(1, 4'b0001, 0, 0, 0); endtask
  task automatic mrs(input logic [2:0] o); issue(1, 4'b0000, 0, 0, o); endtask
  task automatic emrs(input logic [2:0] o); issue(1, 4'b0000, 1, 0, o); endtask
  task automatic settle(); idle(16); prea(0); idle(16); endtask

  task automatic chk_code(input string rq, input int exp);
    checks++;
    if (code !== 4'(exp) || viol !== (exp != 0)) begin
      fails++;
      $display("FAIL %s code=%0d viol=%0b expected code=%0d", rq, code, viol, exp);
    end
  endtask

  task automatic chk_open(input string rq, input logic [3:0] exp);
    checks++;
    if (bank_open !== exp) begin
      fails++;
      $display("FAIL %s open=%b expected %b", rq, bank_open, exp);
    end
  endtask

  task automatic chk_cmd(input string rq, input int exp);
    checks++;
    if (cmd_o !== 4'(exp)) begin
      fails++;
      $display("FAIL %s cmd=%0d expected %0d", rq, cmd_o, exp);
    end
  endtask

  task automatic t_reset();  // R2
    chk_cmd("R2", 0); chk_open("R2", 4'b0000); chk_code("R2", 0);
    act(3); chk_code("R2", 0); chk_open("R2", 4'b1000); chk_cmd("R1", 2);
    settle();
  endtask

  task automatic t_decode();  // R1
    nop();  chk_cmd("R1", 1); chk_code("R1", 0);
    issue(1, 4'b1000, 0, 0, 0); chk_cmd("R1", 0);
    issue(0, 4'b0011, 0, 0, 0); chk_cmd("R1", 13); chk_open("R1", 4'b0000);
    issue(1, 4'b0110, 0, 0, 0); chk_cmd("R1", 12); chk_code("R1", 0);
    settle();
  endtask

  task automatic t_state_track();  // R3
    act(0); idle(2); act(1); idle(2); act(2);
    chk_open("R3", 4'b0111); chk_code("R3", 0);
    idle(10); pre(1); chk_open("R3", 4'b0101); chk_cmd("R3", 7); chk_code("R3", 0);
    prea(1); chk_open("R3", 4'b0000); chk_cmd("R3", 8); chk_code("R3", 0);
    settle();
  endtask

  task automatic t_state_viol();  // R4
    act(2); idle(9);
    act(2);   chk_code("R4", 1);
    rd(3, 0); chk_code("R4", 2); chk_cmd("R4", 3);
    wr(3, 0); chk_code("R4", 2);
    refr();   chk_code("R4", 3);
    mrs(2);   chk_code("R4", 3);
    emrs(0);  chk_code("R4", 3);
    settle();
  endtask

  task automatic t_act_spacing();  // R5, R7 tRAS
    act(0); idle(6); pre(0); chk_code("R5", 0); chk_open("R5", 4'b0000);
    act(0); chk_code("R5", 7);
    settle();
    act(0); idle(2); pre(0); chk_code("R7", 5);
    idle(2); act(0); chk_code("R5", 6);
    settle();
    act(0); act(1); chk_code("R5", 8);
    settle();
  endtask

  task automatic t_col_spacing();  // R6
    act(1); rd(1, 0); chk_code("R6", 4);
    idle(1); rd(1, 0); chk_code("R6", 0);
    rd(1, 0); chk_code("R6", 0);
    settle();
  endtask

  task automatic t_write_rec();  // R7
    act(0); idle(2); wr(0, 0); chk_code("R7", 0);
    idle(5); pre(0); chk_code("R7", 0);
    settle();
    act(0); idle(2); wr(0, 0); idle(4); pre(0); chk_code("R7", 10);
    settle();
  endtask

  task automatic t_rda();  // R8
    act(2); idle(2); rd(2, 1); chk_code("R8", 0); chk_open("R8", 4'b0000);
    idle(5); act(2); chk_code("R8", 11);
    settle();
    act(2); idle(2); rd(2, 1); idle(6); act(2); chk_code("R8", 0);
    settle();
    act(2); idle(9); rd(2, 1); idle(3); act(2); chk_code("R8", 11);
    settle();
  endtask

  task automatic t_wra();  // R9
    act(1); idle(9); wr(1, 1); chk_code("R9", 0);
    idle(7); act(1); chk_code("R9", 11);
    settle();
    act(1); idle(9); wr(1, 1); idle(8); act(1); chk_code("R9", 0);
    settle();
  endtask

  task automatic t_mode_refresh();  // R11, R12
    act(0); idle(6); pre(0); idle(1); mrs(2); chk_code("R11", 7);
    settle();
    mrs(2); act(0); chk_code("R11", 13);
    settle();
    refr(); idle(10); act(0); chk_code("R11", 12);
    settle();
    refr(); chk_code("R11", 0); idle(11); act(0); chk_code("R11", 0);
    settle();
    refr(); rd(2, 0); chk_code("R12", 2);
    settle();
    act(0); idle(3); mrs(2); chk_code("R12", 3);
    act(0); chk_code("R12", 1);
    settle();
  endtask

  task automatic t_burst_len();  // R10
    mrs(3); chk_code("R10", 0); idle(1);
    act(0); idle(9); rd(0, 1); idle(5); act(0); chk_code("R10", 11);
    settle();
    mrs(1); idle(1);
    act(0); idle(9); rd(0, 1); idle(3); act(0); chk_code("R10", 0);
    settle();
    emrs(3); idle(1);
    act(0); idle(9); rd(0, 1); idle(3); act(0); chk_code("R10", 0);
    settle();
    mrs(6); idle(1);
    act(0); idle(9); rd(0, 1); idle(3); act(0); chk_code("R10", 0);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_decode();
    t_state_track();
    t_state_viol();
    t_act_spacing();
    t_col_spacing();
    t_write_rec();
    t_rda();
    t_wra();
    t_mode_refresh();
    t_burst_len();
    summary();
    $finish;
  end
endmodule